// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting ticks of a slow oscillator, which reach it as a single-cycle enable in the system clock domain. Software must service the counter with a clear strobe before the count runs out. If it does not, the block raises a system-reset request. In window mode the period is split in two. First comes a closed window, in which a clear is treated as a fault. Then comes an open window, in which a clear is accepted.

An early-warning pulse is issued a coded number of ticks after each period starts, so software gets notice before the deadline. Every length (the timeout or open window, the closed window and the early-warning offset) comes from a 4-bit code that selects 8·2^n ticks. Codes above 11 select the longest length, 16384 ticks.

An always-on input locks the watchdog running until power-on reset. A run-in-standby input chooses whether counting continues while the system reports standby. Once the reset request is raised, it stays asserted until power-on reset.

Top module: `watchdog_win`

## Requirements
- R1: During and right after power-on reset (`rst`), `rst_req` is 0, `ewarn_pulse` is 0 and `phase_o` is 0 (idle).
- R2: Code n in 0..11 selects a length of 8·2^n ticks. The `phase_o` encoding is 0 idle, 1 closed window, 2 open window or normal period, 3 reset requested.
- R3: With `cfg_win_en`=0, the watchdog enters phase 2 one cycle after it starts running. It reaches phase 3 (`rst_req`=1) on the tick that brings the count to the length set by `cfg_period`.
- R4: With `cfg_win_en`=1, the watchdog starts in phase 1 for `cfg_closed` ticks. It then stays in phase 2 for `cfg_period` more ticks, then enters phase 3.
- R5: A clear in phase 2 restarts the count from zero, in phase 1 when windowed and in phase 2 when not. An input tick in the same cycle is not counted.
- R6: A clear in phase 1 moves the block to phase 3 with `rst_req`=1 in the next cycle.
- R7: `ewarn_pulse` is a one-cycle pulse. It follows the tick that brings the count since the last restart to the `cfg_ewarn` length, provided that length does not exceed the period end. It fires at most once per period.
- R8: Codes 12..15 behave as the 16384-tick length.
- R9: With always-on never set since reset, dropping `cfg_enable` returns the block to phase 0 in the next cycle and discards the count. Enabling again starts a fresh period.
- R10: Once `cfg_always_on` has been 1 for one clock, the watchdog runs whatever `cfg_enable` and `cfg_always_on` do afterwards, until power-on reset.
- R11: While `standby_i`=1 and `cfg_run_stdby`=0, ticks are not counted. With `cfg_run_stdby`=1, ticks are counted during standby.
- R12: Phase 3 and `rst_req`=1 hold until power-on reset, whatever the clear, enable or tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| tick_en | input | 1 | One-cycle tick from the slow oscillator |
| clear_i | input | 1 | Service strobe from software |
| standby_i | input | 1 | System is in standby |
| cfg_enable | input | 1 | Run enable |
| cfg_always_on | input | 1 | Lock the watchdog running until power-on reset |
| cfg_run_stdby | input | 1 | Keep counting during standby |
| cfg_win_en | input | 1 | Select window mode |
| cfg_period | input | 4 | Timeout or open-window length code |
| cfg_closed | input | 4 | Closed-window length code |
| cfg_ewarn | input | 4 | Early-warning offset code |
| rst_req | output | 1 | System-reset request, sticky |
| ewarn_pulse | output | 1 | Early-warning interrupt pulse |
| phase_o | output | 2 | Current phase: 0 idle, 1 closed, 2 open, 3 reset requested |

## Verification
The bound checker watches several properties on every cycle. It checks that the reset request is sticky, that the warning never lasts two cycles, and that a clear in the closed window leads to the reset request. It also checks that a frozen count stays frozen in standby, and that a disable without the lock returns the block to idle.

The exact tick on which each phase boundary, early warning and timeout lands can only be shown by the bench. Its scenarios compare every cycle against lengths computed from the codes. They cover random code choices, clears at random points, a reserved code, the always-on lock, both standby settings and the first tick after each restart.

// File: rtl/watchdog_win_pkg.sv
package watchdog_win_pkg;

    localparam int CODE_W    = 4;
    localparam int CNT_W     = 16;
    localparam int MAX_CODE  = 11;
    localparam int BASE_LOG2 = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2,
        PH_BITE   = 2'd3
    } wdt_phase_e;

    typedef struct packed {
        logic run;
        logic step;
    } wdt_ctl_t;

    function automatic logic [CNT_W-1:0] code_len(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        if (int'(code) > MAX_CODE)
            return one << (MAX_CODE + BASE_LOG2);
        return one << (int'(code) + BASE_LOG2);
    endfunction

endpackage

// File: rtl/wdt_len_decode.sv
module wdt_len_decode
    import watchdog_win_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  len_o
);
    always_comb len_o = code_len(code_i);
endmodule

// File: rtl/wdt_run_ctrl.sv
module wdt_run_ctrl
    import watchdog_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  logic     standby_i,
    input  logic     cfg_enable,
    input  logic     cfg_always_on,
    input  logic     cfg_run_stdby,
    output logic     lock_q,
    output wdt_ctl_t ctl_o
);
    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (cfg_always_on)
            lock_q <= 1'b1;
    end

    always_comb begin
        ctl_o.run  = cfg_always_on | lock_q | cfg_enable;
        ctl_o.step = ctl_o.run & tick_en & (~standby_i | cfg_run_stdby);
    end
endmodule

// File: rtl/wdt_phase_ctrl.sv
module wdt_phase_ctrl
    import watchdog_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wdt_ctl_t         ctl_i,
    input  logic             clear_i,
    input  logic             win_en,
    input  logic [CNT_W-1:0] closed_len,
    input  logic [CNT_W-1:0] open_len,
    output wdt_phase_e       phase_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             step_fire,
    output logic [CNT_W-1:0] cnt_next
);
    logic             active;
    logic [CNT_W-1:0] end_cnt;
    wdt_phase_e       start_ph;

    always_comb begin
        active    = (phase_q == PH_CLOSED) || (phase_q == PH_OPEN);
        start_ph  = win_en ? PH_CLOSED : PH_OPEN;
        end_cnt   = win_en ? (closed_len + open_len) : open_len;
        cnt_next  = cnt_q + CNT_W'(1);
        step_fire = active && ctl_i.run && !clear_i && ctl_i.step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_BITE: begin
                    phase_q <= PH_BITE;
                end
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (ctl_i.run)
                        phase_q <= start_ph;
                end
                default: begin
                    if (!ctl_i.run) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else if (clear_i) begin
                        if (phase_q == PH_CLOSED) begin
                            phase_q <= PH_BITE;
                        end else begin
                            phase_q <= start_ph;
                            cnt_q   <= '0;
                        end
                    end else if (step_fire) begin
                        cnt_q <= cnt_next;
                        if (phase_q == PH_CLOSED && cnt_next >= closed_len)
                            phase_q <= PH_OPEN;
                        if (phase_q == PH_OPEN && cnt_next >= end_cnt)
                            phase_q <= PH_BITE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wdt_ewarn_gen.sv
module wdt_ewarn_gen
    import watchdog_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_fire,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] ew_len,
    output logic             ewarn_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ewarn_q <= 1'b0;
        else
            ewarn_q <= step_fire && (cnt_next == ew_len);
    end
endmodule

// File: rtl/watchdog_win.sv
module watchdog_win
    import watchdog_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              clear_i,
    input  logic              standby_i,
    input  logic              cfg_enable,
    input  logic              cfg_always_on,
    input  logic              cfg_run_stdby,
    input  logic              cfg_win_en,
    input  logic [CODE_W-1:0] cfg_period,
    input  logic [CODE_W-1:0] cfg_closed,
    input  logic [CODE_W-1:0] cfg_ewarn,
    output logic              rst_req,
    output logic              ewarn_pulse,
    output logic [1:0]        phase_o
);
    localparam int N_CODES = 3;

    logic [CODE_W-1:0] codes [N_CODES];
    logic [CNT_W-1:0]  lens  [N_CODES];
    wdt_ctl_t          ctl;
    wdt_phase_e        phase_q;
    logic              lock_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  cnt_next;
    logic              step_fire;

    assign codes[0] = cfg_period;
    assign codes[1] = cfg_closed;
    assign codes[2] = cfg_ewarn;

    for (genvar i = 0; i < N_CODES; i++) begin : g_dec
        wdt_len_decode u_dec (
            .code_i(codes[i]),
            .len_o (lens[i])
        );
    end

    wdt_run_ctrl u_run (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .standby_i    (standby_i),
        .cfg_enable   (cfg_enable),
        .cfg_always_on(cfg_always_on),
        .cfg_run_stdby(cfg_run_stdby),
        .lock_q       (lock_q),
        .ctl_o        (ctl)
    );

    wdt_phase_ctrl u_phase (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .clear_i   (clear_i),
        .win_en    (cfg_win_en),
        .closed_len(lens[1]),
        .open_len  (lens[0]),
        .phase_q   (phase_q),
        .cnt_q     (count_q),
        .step_fire (step_fire),
        .cnt_next  (cnt_next)
    );

    wdt_ewarn_gen u_ew (
        .clk      (clk),
        .rst      (rst),
        .step_fire(step_fire),
        .cnt_next (cnt_next),
        .ew_len   (lens[2]),
        .ewarn_q  (ewarn_pulse)
    );

    assign phase_o = phase_q;
    assign rst_req = (phase_q == PH_BITE);
endmodule

// File: rtl/watchdog_win_chk.sv
module watchdog_win_chk
    import watchdog_win_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clear_i,
    input logic             standby_i,
    input logic             cfg_enable,
    input logic             cfg_always_on,
    input logic             cfg_run_stdby,
    input logic             rst_req,
    input logic             ewarn_pulse,
    input logic [1:0]       phase_o,
    input logic [CNT_W-1:0] count_q,
    input logic             lock_q
);
    logic live;
    assign live = (phase_o == 2'd1) || (phase_o == 2'd2);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase_o == 2'd0 && !rst_req && !ewarn_pulse));

    assert_closed_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1 && clear_i && (cfg_enable || cfg_always_on)) |=> rst_req);

    assert_ewarn_single_R7: assert property (@(posedge clk) disable iff (rst)
        ewarn_pulse |=> !ewarn_pulse);

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (live && !cfg_enable && !cfg_always_on && !lock_q) |=> phase_o == 2'd0);

    assert_lock_run_R10: assert property (@(posedge clk) disable iff (rst)
        (lock_q && phase_o == 2'd0) |=> phase_o != 2'd0);

    assert_standby_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (live && standby_i && !cfg_run_stdby && !clear_i && (cfg_enable || lock_q))
        |=> $stable(count_q));

    assert_bite_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (rst_req && phase_o == 2'd3));
endmodule

bind watchdog_win watchdog_win_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (clear_i),
    .standby_i    (standby_i),
    .cfg_enable   (cfg_enable),
    .cfg_always_on(cfg_always_on),
    .cfg_run_stdby(cfg_run_stdby),
    .rst_req      (rst_req),
    .ewarn_pulse  (ewarn_pulse),
    .phase_o      (phase_o),
    .count_q      (count_q),
    .lock_q       (lock_q)
);

// File: tb/watchdog_win_tb.sv
module watchdog_win_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 0, clear_i = 0, standby_i = 0;
    logic cfg_enable = 0, cfg_always_on = 0, cfg_run_stdby = 0, cfg_win_en = 0;
    logic [3:0] cfg_period = 0, cfg_closed = 0, cfg_ewarn = 0;
    logic rst_req, ewarn_pulse;
    logic [1:0] phase_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    watchdog_win u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .clear_i(clear_i),
        .standby_i(standby_i), .cfg_enable(cfg_enable),
        .cfg_always_on(cfg_always_on), .cfg_run_stdby(cfg_run_stdby),
        .cfg_win_en(cfg_win_en), .cfg_period(cfg_period),
        .cfg_closed(cfg_closed), .cfg_ewarn(cfg_ewarn),
        .rst_req(rst_req), .ewarn_pulse(ewarn_pulse), .phase_o(phase_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_fail++;
            $display("FAIL watchdog expired: act cyc=%0d exp below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int blen(input logic [3:0] c);
        return (c > 4'd11) ? 16384 : (8 << c);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic por();
        @(negedge clk);
        rst = 1; tick_en = 0; clear_i = 0; standby_i = 0;
        cfg_enable = 0; cfg_always_on = 0; cfg_run_stdby = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // enable with ticks off; phase must be start one cycle later
    task automatic start(input string req);
        cfg_enable = 1; tick_en = 0;
        @(negedge clk);
        chk({req, " start phase"}, phase_o, cfg_win_en ? 1 : 2);
        chk({req, " no rst_req at start"}, rst_req, 0);
    endtask

    // tick every cycle for counts k = k0..k1, checking each cycle
    task automatic run_ticks(input string req, input int k0, input int k1);
        int cl, en, ew;
        cl = cfg_win_en ? blen(cfg_closed) : 0;
        en = cl + blen(cfg_period);
        ew = blen(cfg_ewarn);
        tick_en = 1;
        for (int k = k0; k <= k1; k++) begin
            int ep;
            @(negedge clk);
            ep = (k < cl) ? 1 : ((k < en) ? 2 : 3);
            chk({req, " phase"}, phase_o, ep);
            chk({req, " rst_req"}, rst_req, (ep == 3) ? 1 : 0);
            chk({req, " ewarn"}, ewarn_pulse, (k == ew && k <= en) ? 1 : 0);
        end
    endtask

    function automatic int endk();
        return (cfg_win_en ? blen(cfg_closed) : 0) + blen(cfg_period);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        chk("R1 reset phase", phase_o, 0);
        chk("R1 reset rst_req", rst_req, 0);
        chk("R1 reset ewarn", ewarn_pulse, 0);
        rst = 0;

        // R2 R3 R7: normal mode, random codes
        for (int i = 0; i < 6; i++) begin
            por();
            cfg_win_en = 0;
            cfg_period = 4'($urandom_range(0, 4));
            cfg_ewarn  = 4'($urandom_range(0, 5));
            start("R3");
            run_ticks("R3_R2_R7 normal", 1, endk() + 3);
        end

        // R4 R7: window mode, random codes
        for (int i = 0; i < 6; i++) begin
            por();
            cfg_win_en = 1;
            cfg_closed = 4'($urandom_range(0, 4));
            cfg_period = 4'($urandom_range(0, 4));
            cfg_ewarn  = 4'($urandom_range(0, 6));
            start("R4");
            run_ticks("R4_R7 window", 1, endk() + 3);
        end

        // R5: clear in open window at random points (both modes)
        for (int i = 0; i < 6; i++) begin
            int c;
            por();
            cfg_win_en = 1'(i & 1);
            cfg_closed = 4'($urandom_range(0, 3));
            cfg_period = 4'($urandom_range(1, 4));
            cfg_ewarn  = 4'($urandom_range(0, 4));
            start("R5");
            c = (cfg_win_en ? blen(cfg_closed) : 0) + int'($urandom_range(0, blen(cfg_period) - 1));
            run_ticks("R5 before clear", 1, c);
            clear_i = 1;
            @(negedge clk);
            clear_i = 0;
            chk("R5 restart phase", phase_o, cfg_win_en ? 1 : 2);
            chk("R5 no ewarn on clear", ewarn_pulse, 0);
            run_ticks("R5 after clear", 1, endk() + 2);
        end

        // R6: clear in closed window
        por();
        cfg_win_en = 1; cfg_closed = 4'd2; cfg_period = 4'd1; cfg_ewarn = 4'd9;
        start("R6");
        run_ticks("R6 closed", 1, 5);
        clear_i = 1;
        @(negedge clk);
        clear_i = 0;
        chk("R6 rst_req", rst_req, 1);
        chk("R6 phase", phase_o, 3);

        // R12: held through clear, disable and ticks
        clear_i = 1; cfg_enable = 0; tick_en = 1;
        repeat (20) @(negedge clk);
        clear_i = 0;
        chk("R12 rst_req held", rst_req, 1);
        chk("R12 phase held", phase_o, 3);
        por();
        chk("R12 POR releases", rst_req, 0);

        // R8: reserved code acts as 16384
        por();
        cfg_win_en = 0; cfg_period = 4'hD; cfg_ewarn = 4'hF;
        start("R8");
        run_ticks("R8 reserved", 1, 16386);

        // R9: disable discards count, re-enable starts fresh
        por();
        cfg_win_en = 0; cfg_period = 4'd1; cfg_ewarn = 4'd0;
        start("R9");
        run_ticks("R9 first", 1, 12);
        cfg_enable = 0;
        repeat (30) @(negedge clk);
        chk("R9 idle", phase_o, 0);
        chk("R9 no rst_req", rst_req, 0);
        start("R9 again");
        run_ticks("R9 fresh count", 1, 18);

        // R10: always-on lock survives enable=0 and always_on=0
        por();
        cfg_win_en = 0; cfg_period = 4'd2; cfg_ewarn = 4'd1;
        cfg_enable = 0; cfg_always_on = 1;
        @(negedge clk);
        cfg_always_on = 0;
        chk("R10 running", phase_o, 2);
        run_ticks("R10 locked", 1, 34);
        chk("R10 bite with enable low", rst_req, 1);

        // R11: standby freeze when run_stdby=0
        por();
        cfg_win_en = 0; cfg_period = 4'd0; cfg_ewarn = 4'd1;
        start("R11");
        run_ticks("R11 pre", 1, 3);
        standby_i = 1;
        repeat (40) @(negedge clk);
        chk("R11 frozen phase", phase_o, 2);
        chk("R11 frozen no rst_req", rst_req, 0);
        standby_i = 0;
        run_ticks("R11 resume", 4, 10);

        // R11: counting continues with run_stdby=1
        por();
        cfg_win_en = 0; cfg_period = 4'd0; cfg_ewarn = 4'd0; cfg_run_stdby = 1;
        standby_i = 1;
        start("R11 stdby run");
        run_ticks("R11 stdby run", 1, 10);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule